// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects 96 interrupt sources into three banks of 32 (low, high and pin) and drives a single CPU interrupt line. Each bank has a cause register and a mask register on a small synchronous bus with 32-bit data and byte addresses. A window-select input picks between the main window and the pin window. The pin bank does not reach the CPU directly. Four summary bits in the high bank carry it, and each summary bit covers one group of eight pin sources.

Software can take one of two paths. It can read a select word, which reports whether the high bank or the low bank has work and returns that bank's cause. It can also read a resolved vector, which already names the bank and the highest-numbered enabled pending source. Causes in the low and high banks are level-sensitive. Pin causes latch on a rising edge. Cause bits in every bank are cleared with a write-zero-to-clear word.

Top module: `casc_intc`

## Requirements
- R1: After reset the low mask and the pin mask read 0. The high mask reads 0x0F000000. All causes are clear, the vector reads 0 and `cpu_irq` is low.
- R2: A low-bank or high-bank cause bit is set in the cycle after its source input is high. It stays set after the input falls. A clearing write has no effect on it while the input stays high.
- R3: A write to any cause register keeps each bit written as 1 and clears each bit written as 0, so writing 0 clears the whole register.
- R4: A pin cause bit is set on a rising edge of its input. A clearing write while the input is held high leaves the bit clear.
- R5: Bits 27:24 of the high cause read back as summaries. Bit 24+g is the OR of pin causes 8g..8g+7 ANDed with their pin mask bits. The `src_high` inputs on bits 27:24 have no effect.
- R6: The select word at main offset 0x24 behaves as follows. If any enabled high cause is pending, it returns the high cause with bit 30 forced to 1. Otherwise it returns the low cause with bit 30 forced to 0.
- R7: The vector at main offset 0x28 has bit 7 as valid, bits 6:5 as the bank code (0 low, 1 high, 2 pin) and bits 4:0 as the index. The pin bank is used when an enabled summary bit is pending. The high bank is used when another enabled high cause is pending, and the low bank is used otherwise. The vector reads 0 when nothing enabled is pending, and code 3 never appears.
- R8: Within the chosen bank, the highest-numbered bit that is both pending and enabled is reported.
- R9: `cpu_irq` is the registered OR of all enabled pending causes in the low and high banks, with the pin bank counted through the summaries. It rises or falls one cycle after the causes change. Masked causes do not raise it.
- R10: The main window places the low cause at 0x04, the high cause at 0x0C, the low mask at 0x14 and the high mask at 0x1C. The pin window places the pin cause at 0x08 and the pin mask at 0x0C. Unmapped offsets read 0. `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_win | input | 1 | Window select: 0 main, 1 pin |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_low | input | 32 | Low-bank sources 0-31 |
| src_high | input | 32 | High-bank sources 32-63 (bits 27:24 unused) |
| src_pin | input | 32 | Pin-bank sources 64-95 |
| cpu_irq | output | 1 | CPU interrupt request |

## Verification
The assertions assume that every source and bus input is synchronous to `clk` and changes only between rising edges. They also assume that one bus strobe is active per cycle and that the checker's copy of the previous pin levels starts from the same reset as the design. The directed tasks meet these assumptions in three ways. They drive every input on the falling edge. They issue reads and writes as single-cycle strobes that never overlap. They hold all sources low through reset, so the first pin edge the block sees is one the bench created on purpose.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int BANK_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_GRP  = 4;
    localparam int GRP_W    = BANK_W / NUM_GRP;
    localparam int SUM_LSB  = 24;
    localparam int SEL_FLAG = 30;
    localparam int IDX_W    = $clog2(BANK_W);

    localparam logic [BANK_W-1:0] SUM_FIELD =
        {{(BANK_W-SUM_LSB-NUM_GRP){1'b0}}, {NUM_GRP{1'b1}}, {SUM_LSB{1'b0}}};
    localparam logic [BANK_W-1:0] HIGH_MASK_RST = SUM_FIELD;
    localparam logic [BANK_W-1:0] FLAG_BIT = BANK_W'(1) << SEL_FLAG;

    localparam logic [ADDR_W-1:0] OFS_LOW_CAUSE  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_HIGH_CAUSE = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_LOW_MASK   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_HIGH_MASK  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SELECT     = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_VECTOR     = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_PIN_CAUSE  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PIN_MASK   = 8'h0C;

    typedef enum logic [1:0] {
        BANK_LOW  = 2'd0,
        BANK_HIGH = 2'd1,
        BANK_PIN  = 2'd2
    } bank_code_e;
endpackage

// File: rtl/intc_msb_enc.sv
module intc_msb_enc #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Later iterations overwrite earlier ones: highest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign hit = |vec;
endmodule

// File: rtl/intc_cause_bank.sv
module intc_cause_bank #(
    parameter int         W     = 32,
    parameter bit         EDGE  = 1'b0,
    parameter logic [W-1:0] LIVE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         wr_en,
    input  logic [W-1:0] keep,
    output logic [W-1:0] cause
);
    logic [W-1:0] set_vec;
    logic [W-1:0] keep_vec;

    generate
        if (EDGE) begin : g_edge
            logic [W-1:0] prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= src;
            end
            assign set_vec = src & ~prev_q & LIVE;
        end else begin : g_level
            assign set_vec = src & LIVE;
        end
    endgenerate

    assign keep_vec = wr_en ? keep : {W{1'b1}};

    // A set request in the same cycle as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause <= '0;
        else        cause <= (cause & keep_vec) | set_vec;
    end
endmodule

// File: rtl/casc_intc.sv
module casc_intc
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [BANK_W-1:0] src_low,
    input  logic [BANK_W-1:0] src_high,
    input  logic [BANK_W-1:0] src_pin,
    output logic              cpu_irq
);
    logic              main_wr, pin_wr;
    logic              wr_low_cause, wr_high_cause, wr_pin_cause;
    logic [BANK_W-1:0] cause_low_q, cause_hstore_q, cause_pin_q;
    logic [BANK_W-1:0] mask_low_q, mask_high_q, mask_pin_q;
    logic [BANK_W-1:0] pin_live, low_live, high_live, cause_high_eff;
    logic [NUM_GRP-1:0] summary;
    logic              low_hit, high_hit, pin_hit, pin_route;
    logic [IDX_W-1:0]  low_idx, high_idx, pin_idx;
    logic [BANK_W-1:0] select_word, vec_word, rd_mux;
    logic              irq_q;

    // Write decode
    assign main_wr       = bus_wr && !bus_win;
    assign pin_wr        = bus_wr &&  bus_win;
    assign wr_low_cause  = main_wr && (bus_addr == OFS_LOW_CAUSE);
    assign wr_high_cause = main_wr && (bus_addr == OFS_HIGH_CAUSE);
    assign wr_pin_cause  = pin_wr  && (bus_addr == OFS_PIN_CAUSE);

    // Cause banks
    intc_cause_bank #(.W(BANK_W), .EDGE(1'b0), .LIVE({BANK_W{1'b1}})) u_bank_low (
        .clk(clk), .rst_n(rst_n), .src(src_low),
        .wr_en(wr_low_cause), .keep(bus_wdata), .cause(cause_low_q));

    intc_cause_bank #(.W(BANK_W), .EDGE(1'b0), .LIVE(~SUM_FIELD)) u_bank_high (
        .clk(clk), .rst_n(rst_n), .src(src_high),
        .wr_en(wr_high_cause), .keep(bus_wdata), .cause(cause_hstore_q));

    intc_cause_bank #(.W(BANK_W), .EDGE(1'b1), .LIVE({BANK_W{1'b1}})) u_bank_pin (
        .clk(clk), .rst_n(rst_n), .src(src_pin),
        .wr_en(wr_pin_cause), .keep(bus_wdata), .cause(cause_pin_q));

    // Mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_low_q  <= '0;
            mask_high_q <= HIGH_MASK_RST;
            mask_pin_q  <= '0;
        end else begin
            if (main_wr && bus_addr == OFS_LOW_MASK)  mask_low_q  <= bus_wdata;
            if (main_wr && bus_addr == OFS_HIGH_MASK) mask_high_q <= bus_wdata;
            if (pin_wr  && bus_addr == OFS_PIN_MASK)  mask_pin_q  <= bus_wdata;
        end
    end

    // Cascade: pin groups fold into high-bank summary bits
    assign pin_live = cause_pin_q & mask_pin_q;

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_sum
            assign summary[g] = |pin_live[g*GRP_W +: GRP_W];
        end
    endgenerate

    assign cause_high_eff = (cause_hstore_q & ~SUM_FIELD) |
                            ({{(BANK_W-NUM_GRP){1'b0}}, summary} << SUM_LSB);
    assign low_live  = cause_low_q & mask_low_q;
    assign high_live = cause_high_eff & mask_high_q;
    assign pin_route = |(high_live & SUM_FIELD);

    // Priority encoders
    intc_msb_enc #(.W(BANK_W), .IW(IDX_W)) u_enc_low  (.vec(low_live),  .hit(low_hit),  .idx(low_idx));
    intc_msb_enc #(.W(BANK_W), .IW(IDX_W)) u_enc_high (.vec(high_live), .hit(high_hit), .idx(high_idx));
    intc_msb_enc #(.W(BANK_W), .IW(IDX_W)) u_enc_pin  (.vec(pin_live),  .hit(pin_hit),  .idx(pin_idx));

    // Select word and resolved vector
    assign select_word = high_hit ? (cause_high_eff | FLAG_BIT)
                                  : (cause_low_q & ~FLAG_BIT);

    always_comb begin
        vec_word = '0;
        if (pin_route && pin_hit)
            vec_word = {{(BANK_W-IDX_W-3){1'b0}}, 1'b1, BANK_PIN, pin_idx};
        else if (high_hit)
            vec_word = {{(BANK_W-IDX_W-3){1'b0}}, 1'b1, BANK_HIGH, high_idx};
        else if (low_hit)
            vec_word = {{(BANK_W-IDX_W-3){1'b0}}, 1'b1, BANK_LOW, low_idx};
    end

    // Read path
    always_comb begin
        rd_mux = '0;
        if (!bus_win) begin
            case (bus_addr)
                OFS_LOW_CAUSE:  rd_mux = cause_low_q;
                OFS_HIGH_CAUSE: rd_mux = cause_high_eff;
                OFS_LOW_MASK:   rd_mux = mask_low_q;
                OFS_HIGH_MASK:  rd_mux = mask_high_q;
                OFS_SELECT:     rd_mux = select_word;
                OFS_VECTOR:     rd_mux = vec_word;
                default:        rd_mux = '0;
            endcase
        end else begin
            case (bus_addr)
                OFS_PIN_CAUSE:  rd_mux = cause_pin_q;
                OFS_PIN_MASK:   rd_mux = mask_pin_q;
                default:        rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // CPU line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= low_hit | high_hit;
    end

    assign cpu_irq = irq_q;
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_win,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [BANK_W-1:0] bus_rdata,
    input logic [BANK_W-1:0] src_low,
    input logic [BANK_W-1:0] src_pin,
    input logic              cpu_irq,
    input logic [BANK_W-1:0] low_cause,
    input logic [BANK_W-1:0] pin_cause,
    input logic [BANK_W-1:0] high_eff,
    input logic [BANK_W-1:0] mask_low,
    input logic [BANK_W-1:0] mask_high
);
    logic [BANK_W-1:0] pin_seen_q;
    logic [BANK_W-1:0] pin_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_seen_q <= '0;
        else        pin_seen_q <= src_pin;
    end
    assign pin_rise = src_pin & ~pin_seen_q;

    AST_RESET_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_low == '0 && mask_high == HIGH_MASK_RST)); // R1
    AST_LOW_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (src_low != '0) |=> ((low_cause & $past(src_low)) == $past(src_low))); // R2
    AST_PIN_RISE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rise != '0) |=> ((pin_cause & $past(pin_rise)) == $past(pin_rise))); // R4
    AST_SEL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_win && bus_addr == OFS_SELECT) |=>
        (bus_rdata[SEL_FLAG] == $past((high_eff & mask_high) != '0))); // R6
    AST_VEC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_win && bus_addr == OFS_VECTOR) |=> (bus_rdata[6:5] != 2'b11)); // R7
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> $past(((low_cause & mask_low) != '0) || ((high_eff & mask_high) != '0))); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

bind casc_intc intc_checker u_intc_checker (
    .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .src_low(src_low), .src_pin(src_pin),
    .cpu_irq(cpu_irq), .low_cause(cause_low_q), .pin_cause(cause_pin_q),
    .high_eff(cause_high_eff), .mask_low(mask_low_q), .mask_high(mask_high_q));

// File: tb/casc_intc_bench.sv
module casc_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_win = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_low = '0, src_high = '0, src_pin = '0;
    logic        cpu_irq;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    casc_intc u_casc_intc (
        .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_low(src_low), .src_high(src_high), .src_pin(src_pin), .cpu_irq(cpu_irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic win, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_win = win; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic win, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_win = win; bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
        do_read(1'b0, 8'h14, v); chk("R1 low mask", v, 32'h0);
        do_read(1'b0, 8'h1C, v); chk("R1 high mask", v, 32'h0F000000);
        do_read(1'b1, 8'h0C, v); chk("R1 pin mask", v, 32'h0);
        do_read(1'b0, 8'h28, v); chk("R1 vector", v, 32'h0);
        do_read(1'b0, 8'h04, v); chk("R1 low cause", v, 32'h0);
    endtask

    task automatic t_low_level();
        logic [31:0] v;
        do_write(1'b0, 8'h14, 32'hFFFFFFFF);
        @(negedge clk); src_low = 32'h00020008;
        @(negedge clk); @(negedge clk);
        chk("R9 irq raised", {31'b0, cpu_irq}, 32'h1);
        do_read(1'b0, 8'h04, v); chk("R2 level set", v, 32'h00020008);
        do_write(1'b0, 8'h04, 32'h0);
        do_read(1'b0, 8'h04, v); chk("R2 clear while held", v, 32'h00020008);
        src_low = '0;
        do_read(1'b0, 8'h04, v); chk("R2 held after fall", v, 32'h00020008);
        do_write(1'b0, 8'h04, 32'hFFFFFFF7);
        do_read(1'b0, 8'h04, v); chk("R3 keep-ones clear", v, 32'h00020000);
        do_write(1'b0, 8'h04, 32'h0);
        do_read(1'b0, 8'h04, v); chk("R3 write zero", v, 32'h0);
        @(negedge clk);
        chk("R9 irq dropped", {31'b0, cpu_irq}, 32'h0);
        do_write(1'b0, 8'h14, 32'h0);
        src_low = 32'h00000001;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R9 masked no irq", {31'b0, cpu_irq}, 32'h0);
        src_low = '0;
        do_write(1'b0, 8'h04, 32'h0);
    endtask

    task automatic t_vec_low();
        logic [31:0] v;
        do_write(1'b0, 8'h14, 32'hFFFFFFFF);
        src_low = 32'h00000204;
        do_read(1'b0, 8'h28, v); chk("R8 highest low", v, 32'h00000089);
        do_write(1'b0, 8'h14, 32'hFFFFFDFF);
        do_read(1'b0, 8'h28, v); chk("R8 masked top skipped", v, 32'h00000082);
        do_read(1'b0, 8'h24, v); chk("R6 select low", v, 32'h00000204);
        src_low = '0;
        do_write(1'b0, 8'h04, 32'h0);
    endtask

    task automatic t_high();
        logic [31:0] v;
        do_write(1'b0, 8'h14, 32'hFFFFFFFF);
        do_write(1'b0, 8'h1C, 32'h8F000010);
        src_low = 32'h00000001;
        src_high = 32'h82000010;
        do_read(1'b0, 8'h0C, v); chk("R5 src summary ignored", v, 32'h80000010);
        do_read(1'b0, 8'h28, v); chk("R7 high vector", v, 32'h000000BF);
        do_read(1'b0, 8'h24, v); chk("R6 select high", v, 32'hC0000010);
        chk("R9 irq high", {31'b0, cpu_irq}, 32'h1);
        src_low = '0; src_high = '0;
        do_write(1'b0, 8'h04, 32'h0);
        do_write(1'b0, 8'h0C, 32'h0);
        do_write(1'b0, 8'h1C, 32'h0F000000);
    endtask

    task automatic t_pin();
        logic [31:0] v;
        do_write(1'b1, 8'h0C, 32'h80000100);
        @(negedge clk); src_pin = 32'h80000120;
        do_read(1'b1, 8'h08, v); chk("R4 rise latched", v, 32'h80000120);
        do_read(1'b0, 8'h0C, v); chk("R5 summaries", v, 32'h0A000000);
        do_read(1'b0, 8'h28, v); chk("R7 pin vector", v, 32'h000000DF);
        do_read(1'b0, 8'h24, v); chk("R6 select summary", v, 32'h4A000000);
        do_write(1'b1, 8'h08, 32'h7FFFFFFF);
        do_read(1'b1, 8'h08, v); chk("R4 held input no reset", v, 32'h00000120);
        do_read(1'b0, 8'h28, v); chk("R8 pin next highest", v, 32'h000000C8);
        do_write(1'b1, 8'h08, 32'h0);
        do_read(1'b1, 8'h08, v); chk("R3 pin write zero", v, 32'h0);
        do_read(1'b0, 8'h28, v); chk("R7 vector empty", v, 32'h0);
        chk("R9 irq after clear", {31'b0, cpu_irq}, 32'h0);
        src_pin = '0;
    endtask

    task automatic t_map();
        logic [31:0] v;
        do_read(1'b0, 8'h30, v); chk("R10 unmapped main", v, 32'h0);
        do_read(1'b1, 8'h04, v); chk("R10 unmapped pin", v, 32'h0);
        do_read(1'b1, 8'h0C, v); chk("R10 pin mask offset", v, 32'h80000100);
        @(negedge clk); @(negedge clk);
        chk("R10 rdata holds", bus_rdata, 32'h80000100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_level();
        t_vec_low();
        t_high();
        t_pin();
        t_map();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule